// File: doc/BRIEF.md
# Clock Loss Monitor with Interrupt Tree

This block checks that the clocks of several groups of eight sub-units are running. At the end of every programmable test period it inverts a single test signal, `clk_test`, which goes out to all watched sub-units. Each sub-unit returns an acknowledge that follows the test signal in its own clock domain. The block brings every acknowledge into its own clock domain through a synchronizer. In the last cycle of each period it compares the synchronized acknowledge with the test signal. On a mismatch it sets a sticky loss-of-clock bit for that sub-unit.

Loss bits are kept in one 8-bit status register per group, and each status register has its own mask. Each group with an unmasked loss bit raises one bit of a pointer register. The pointer register has its own mask, and any unmasked pointer bit raises the clock-monitor bit of the main interrupt register. That bit also drives the `irq_clkmon` output. Software reaches all registers through a simple strobe-based read and write port. A loss bit can be cleared in two ways: by writing a 1 to it once its clock is back, or through an optional clear-on-read mode that empties the whole register.

Top module: `clock_loss_monitor`

## Requirements
- R1: `clk_test` inverts once every P cycles, where P is the 16-bit period value. A period value of 0 behaves as 1. A write to either period byte (0x04 low, 0x05 high) restarts the count without inverting `clk_test` in that cycle.
- R2: Each acknowledge passes through two flops. In the last cycle of each period, status bit i (register 0x10+g, bit i mod 8, g = i div 8) is set if the synchronized acknowledge differs from `clk_test`. Status bits never set in any other cycle.
- R3: Read data is combinational from `reg_addr`. The address map is: 0x00 main, 0x01 pointer, 0x02 pointer mask, 0x03 config (bit 0 enables clear-on-read), 0x04/0x05 period, 0x10+g status, 0x20+g status mask. Any other address reads 0.
- R4: Writing a 1 to a status bit clears it only if the synchronized acknowledge of that sub-unit changed at least once during the last completed period. Otherwise the bit stays set.
- R5: With config bit 0 set, a read of a status register clears all eight of its bits. With config bit 0 clear, a read changes nothing.
- R6: A mismatch found in the same cycle as a clear (by read or by write) leaves the bit set.
- R7: Pointer bit g is 1 when status register g has a set bit whose mask bit is 0. A mask bit of 1 blocks that status bit.
- R8: Main register bit 0 and `irq_clkmon` are 1 when any pointer bit whose pointer-mask bit is 0 is set.
- R9: Writes to the main and pointer registers, and to unmapped addresses, have no effect.
- R10: After reset, all status, mask and config registers read 0, the period reads 16, and `clk_test` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, used for clear-on-read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ack_in | input | 8*NUM_GROUPS | Acknowledges returned by the watched sub-units |
| clk_test | output | 1 | Test signal sent to all sub-units |
| irq_clkmon | output | 1 | Clock-monitor interrupt (main register bit 0) |

## Verification
The bench targets six corner cases:
- A write-one-to-clear issued while the acknowledge is still stuck. A design that ignored the activity condition would drop a loss that is still present.
- Clear-on-read with the option both disabled and enabled. A design that got this wrong would lose status on every read, or never clear it.
- Reads that clear while a mismatch is being sampled in the same cycle. Here the wrong priority would hide a fresh loss.
- Period values of 0, 2 and 6, written in mid-period. A counter that failed to restart, or that misread the value 0, would drift from the reference and flag healthy units at the wrong times.
- Masks at both levels of the interrupt tree, which check that the interrupt stops when either mask blocks it.
- Writes to the read-only pointer and main registers, which must leave them unchanged.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

   // sub-units per status register
   localparam int GROUP_W = 8;

   // register map
   localparam logic [7:0] A_MAIN       = 8'h00;
   localparam logic [7:0] A_PTR        = 8'h01;
   localparam logic [7:0] A_PMASK      = 8'h02;
   localparam logic [7:0] A_CFG        = 8'h03;
   localparam logic [7:0] A_PER_LO     = 8'h04;
   localparam logic [7:0] A_PER_HI     = 8'h05;
   localparam logic [7:0] A_STAT_BASE  = 8'h10;
   localparam logic [7:0] A_SMASK_BASE = 8'h20;

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   genvar i;
   for (i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/clkmon_timer.sv
module clkmon_timer #(
   parameter int PERIOD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PERIOD_W-1:0] period,
   input  logic                reload,
   output logic                test,
   output logic                sample
);

   localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

   logic [PERIOD_W-1:0] cnt;
   logic [PERIOD_W-1:0] last;

   // a zero period is run as a one-cycle period
   assign last   = (period == '0) ? '0 : period - ONE;
   assign sample = ~reload & (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         test <= 1'b0;
      end else if (reload) begin
         cnt  <= '0;
      end else if (sample) begin
         cnt  <= '0;
         test <= ~test;
      end else begin
         cnt  <= cnt + ONE;
      end
   end

   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) cnt <= last); // R1
   AST_TOGGLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) sample |=> (test != $past(test))); // R1
   AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n) !sample |=> $stable(test)); // R1

endmodule

// File: rtl/clkmon_group.sv
module clkmon_group #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ack,
   input  logic         test,
   input  logic         sample,
   input  logic         wr_stat,
   input  logic         rd_clear,
   input  logic         wr_mask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] status,
   output logic [W-1:0] mask,
   output logic         pending
);

   logic [W-1:0] prev_ack;
   logic [W-1:0] activity;
   logic [W-1:0] alive;
   logic [W-1:0] edges;
   logic [W-1:0] hit;
   logic [W-1:0] drop;

   assign edges = ack ^ prev_ack;
   assign hit   = sample ? (ack ^ {W{test}}) : '0;
   // write-one clears only sub-units whose acknowledge moved last period
   assign drop  = rd_clear ? '1 : (wr_stat ? (wdata & alive) : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= '0;
         mask     <= '0;
         prev_ack <= '0;
         activity <= '0;
         alive    <= '0;
      end else begin
         status   <= hit | (status & ~drop);
         prev_ack <= ack;
         if (sample) begin
            alive    <= activity | edges;
            activity <= '0;
         end else begin
            activity <= activity | edges;
         end
         if (wr_mask) mask <= wdata;
      end
   end

   assign pending = |(status & ~mask);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (hit != '0) |=> ((status & $past(hit)) == $past(hit))); // R6
   AST_SET_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) !sample |=> ((status & ~$past(status)) == '0)); // R2
   AST_STUCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (wr_stat && !rd_clear) |=> ((status & $past(status & wdata & ~alive)) == $past(status & wdata & ~alive))); // R4
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (rd_clear && !sample) |=> (status == '0)); // R5

endmodule

// File: rtl/clock_loss_monitor.sv
module clock_loss_monitor
   import clkmon_pkg::*;
#(
   parameter int NUM_GROUPS  = 2,
   parameter int PERIOD_W    = 16,
   parameter int DEF_PERIOD  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [7:0]                    reg_addr,
   input  logic                          reg_wr,
   input  logic                          reg_rd,
   input  logic [7:0]                    reg_wdata,
   output logic [7:0]                    reg_rdata,
   input  logic [GROUP_W*NUM_GROUPS-1:0] ack_in,
   output logic                          clk_test,
   output logic                          irq_clkmon
);

   localparam int NU    = GROUP_W * NUM_GROUPS;
   localparam int HI_W  = PERIOD_W - 8;

   if (NUM_GROUPS < 1 || NUM_GROUPS > 8) begin : g_bad_groups
      $fatal(1, "NUM_GROUPS must lie in 1..8");
   end
   if (PERIOD_W < 9 || PERIOD_W > 16) begin : g_bad_width
      $fatal(1, "PERIOD_W must lie in 9..16");
   end
   if (DEF_PERIOD < 1 || DEF_PERIOD >= (1 << PERIOD_W)) begin : g_bad_def
      $fatal(1, "DEF_PERIOD does not fit PERIOD_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic [PERIOD_W-1:0]   period_q;
   logic                  cor_q;
   logic [7:0]            pmask_q;
   logic [NU-1:0]         ack_s;
   logic                  sample;
   logic                  reload;
   logic [NUM_GROUPS-1:0] ptr_raw;
   logic [7:0]            ptr_vec;
   logic                  main_bit;
   logic [GROUP_W-1:0]    stat_v  [NUM_GROUPS];
   logic [GROUP_W-1:0]    smask_v [NUM_GROUPS];

   assign reload = reg_wr & ((reg_addr == A_PER_LO) | (reg_addr == A_PER_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= PERIOD_W'(DEF_PERIOD);
         cor_q    <= 1'b0;
         pmask_q  <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_PMASK:  pmask_q                 <= reg_wdata;
            A_CFG:    cor_q                   <= reg_wdata[0];
            A_PER_LO: period_q[7:0]           <= reg_wdata;
            A_PER_HI: period_q[PERIOD_W-1:8]  <= reg_wdata[HI_W-1:0];
            default: ;
         endcase
      end
   end

   clkmon_sync #(.W(NU), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_in),
      .q     (ack_s)
   );

   clkmon_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (period_q),
      .reload (reload),
      .test   (clk_test),
      .sample (sample)
   );

   genvar g;
   for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic sel_stat;
      logic sel_mask;
      assign sel_stat = (reg_addr == A_STAT_BASE  + 8'(g));
      assign sel_mask = (reg_addr == A_SMASK_BASE + 8'(g));

      clkmon_group #(.W(GROUP_W)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .ack      (ack_s[g*GROUP_W +: GROUP_W]),
         .test     (clk_test),
         .sample   (sample),
         .wr_stat  (reg_wr & sel_stat),
         .rd_clear (reg_rd & sel_stat & cor_q),
         .wr_mask  (reg_wr & sel_mask),
         .wdata    (reg_wdata),
         .status   (stat_v[g]),
         .mask     (smask_v[g]),
         .pending  (ptr_raw[g])
      );
   end

   always_comb begin
      ptr_vec = '0;
      ptr_vec[NUM_GROUPS-1:0] = ptr_raw;
   end

   assign main_bit   = |(ptr_vec & ~pmask_q);
   assign irq_clkmon = main_bit;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_MAIN:   reg_rdata[0] = main_bit;
         A_PTR:    reg_rdata = ptr_vec;
         A_PMASK:  reg_rdata = pmask_q;
         A_CFG:    reg_rdata[0] = cor_q;
         A_PER_LO: reg_rdata = period_q[7:0];
         A_PER_HI: reg_rdata[HI_W-1:0] = period_q[PERIOD_W-1:8];
         default: begin
            for (int k = 0; k < NUM_GROUPS; k++) begin
               if (reg_addr == A_STAT_BASE + 8'(k))  reg_rdata = stat_v[k];
               if (reg_addr == A_SMASK_BASE + 8'(k)) reg_rdata = smask_v[k];
            end
         end
      endcase
   end

   AST_IRQ_NEEDS_PTR: assert property (@(posedge clk) disable iff (!rst_n) irq_clkmon |-> (ptr_vec != '0)); // R8

endmodule

// File: tb/clock_loss_monitor_test.sv
`timescale 1ns/1ps
module clock_loss_monitor_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [15:0] ack_in;
   logic        clk_test;
   logic        irq_clkmon;

   logic [15:0] alive = 16'hFFFF;
   logic [15:0] stuck = 16'h0000;

   int total = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   always_comb ack_in = (alive & {16{clk_test}}) | (~alive & stuck);

   clock_loss_monitor uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .ack_in     (ack_in),
      .clk_test   (clk_test),
      .irq_clkmon (irq_clkmon)
   );

   // ---------------- behavioural reference ----------------
   bit [15:0] m_period;
   int        m_cnt;
   bit        m_test;
   bit [15:0] m_s1, m_s2, m_prev, m_act, m_ok, m_stat;
   bit [7:0]  m_smask [2];
   bit [7:0]  m_pmask;
   bit        m_cor;
   bit [15:0] t_ack, t_edges, t_hit, t_drop;
   int        t_eff;
   bit        t_reload, t_smp;

   function automatic bit [7:0] m_ptr();
      bit [7:0] p = 8'h00;
      for (int g = 0; g < 2; g++) p[g] = |(m_stat[8*g +: 8] & ~m_smask[g]);
      return p;
   endfunction

   function automatic bit m_main();
      return |(m_ptr() & ~m_pmask);
   endfunction

   function automatic bit [7:0] m_read(input bit [7:0] a);
      case (a)
         8'h00: return {7'b0, m_main()};
         8'h01: return m_ptr();
         8'h02: return m_pmask;
         8'h03: return {7'b0, m_cor};
         8'h04: return m_period[7:0];
         8'h05: return m_period[15:8];
         8'h10: return m_stat[7:0];
         8'h11: return m_stat[15:8];
         8'h20: return m_smask[0];
         8'h21: return m_smask[1];
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_period = 16; m_cnt = 0; m_test = 0;
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_act = 0; m_ok = 0; m_stat = 0;
         m_smask[0] = 0; m_smask[1] = 0; m_pmask = 0; m_cor = 0;
      end else begin
         t_ack    = (alive & {16{m_test}}) | (~alive & stuck);
         t_eff    = (m_period == 0) ? 1 : int'(m_period);
         t_reload = reg_wr && (reg_addr == 8'h04 || reg_addr == 8'h05);
         t_smp    = !t_reload && (m_cnt == t_eff - 1);
         t_edges  = m_s2 ^ m_prev;
         t_hit    = t_smp ? (m_s2 ^ {16{m_test}}) : 16'h0;
         t_drop   = 16'h0;
         for (int g = 0; g < 2; g++) begin
            if (reg_rd && reg_addr == 8'(8'h10 + g) && m_cor) t_drop[8*g +: 8] = 8'hFF;
            else if (reg_wr && reg_addr == 8'(8'h10 + g)) t_drop[8*g +: 8] = reg_wdata & m_ok[8*g +: 8];
         end
         m_stat = t_hit | (m_stat & ~t_drop);
         if (t_smp) begin m_ok = m_act | t_edges; m_act = 0; end
         else m_act = m_act | t_edges;
         if (reg_wr) begin
            case (reg_addr)
               8'h02: m_pmask = reg_wdata;
               8'h03: m_cor = reg_wdata[0];
               8'h04: m_period[7:0] = reg_wdata;
               8'h05: m_period[15:8] = reg_wdata;
               8'h20: m_smask[0] = reg_wdata;
               8'h21: m_smask[1] = reg_wdata;
               default: ;
            endcase
         end
         if (t_reload) m_cnt = 0;
         else if (t_smp) begin m_cnt = 0; m_test = ~m_test; end
         else m_cnt = m_cnt + 1;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = t_ack;
      end
   end

   // ---------------- checking ----------------
   task automatic check(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic report();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // compare against the reference every cycle, away from the clock edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 clk_test vs model", clk_test, m_test);
         check("R8 irq vs model", irq_clkmon, m_main());
         check("R3 rdata vs model", reg_rdata, m_read(reg_addr));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         total++; fails++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         report();
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input int exp, input string tag);
      @(negedge clk); #1;
      reg_addr = a; reg_rd = 1'b1;
      #0.5;
      check(tag, reg_rdata, m_read(a));
      if (exp >= 0) check(tag, reg_rdata, exp);
      @(negedge clk); #1;
      reg_rd = 1'b0;
   endtask

   initial begin
      bit t0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      check("R10 clk_test after reset", clk_test, 0);
      rd(8'h04, 16, "R10 period low");
      rd(8'h05, 0,  "R10 period high");
      rd(8'h03, 0,  "R10 config");
      rd(8'h10, 0,  "R10 status0");
      rd(8'h21, 0,  "R10 mask1");
      rd(8'h00, 0,  "R10 main");
      rd(8'h3F, 0,  "R3 unmapped reads zero");

      // healthy units with period 6
      wr(8'h04, 8'd6);
      idle(40);
      rd(8'h10, 0, "R2 healthy group0");
      rd(8'h11, 0, "R2 healthy group1");

      // two stopped clocks
      alive[3] = 1'b0;  stuck[3] = 1'b0;
      alive[12] = 1'b0; stuck[12] = 1'b1;
      idle(30);
      rd(8'h10, 8'h08, "R2 loss group0");
      rd(8'h11, 8'h10, "R2 loss group1");
      rd(8'h01, 8'h03, "R7 pointer both");
      rd(8'h00, 8'h01, "R8 main set");
      check("R8 irq set", irq_clkmon, 1);

      // masks at both levels
      wr(8'h20, 8'h08);
      rd(8'h01, 8'h02, "R7 masked group0");
      wr(8'h01, 8'hFF);
      rd(8'h01, 8'h02, "R9 pointer write ignored");
      wr(8'h02, 8'h02);
      rd(8'h00, 8'h00, "R8 pointer mask blocks");
      check("R8 irq blocked", irq_clkmon, 0);
      wr(8'h02, 8'h00);
      wr(8'h00, 8'h00);
      rd(8'h00, 8'h01, "R9 main write ignored");
      wr(8'h3F, 8'hFF);
      rd(8'h10, 8'h08, "R9 unmapped write ignored");

      // write-one-to-clear needs a running clock
      wr(8'h10, 8'h08);
      rd(8'h10, 8'h08, "R4 clear refused while stuck");
      alive[3] = 1'b1;
      idle(20);
      wr(8'h10, 8'h08);
      rd(8'h10, 8'h00, "R4 clear after restore");

      // clear-on-read
      alive[12] = 1'b1;
      idle(20);
      rd(8'h11, 8'h10, "R5 read without option");
      rd(8'h11, 8'h10, "R5 read without option keeps");
      wr(8'h03, 8'h01);
      rd(8'h11, 8'h10, "R5 read with option");
      rd(8'h11, 8'h00, "R5 register emptied");
      wr(8'h03, 8'h00);

      // period 0 behaves as 1
      wr(8'h04, 8'd0);
      idle(3);
      @(negedge clk); t0 = clk_test;
      @(negedge clk);
      check("R1 zero period toggles every cycle", clk_test, !t0);

      // period 2 flags healthy units; reads clear while samples set
      wr(8'h04, 8'd2);
      idle(8);
      wr(8'h03, 8'h01);
      rd(8'h10, -1, "R6 clear vs set 1");
      rd(8'h10, -1, "R6 clear vs set 2");
      rd(8'h10, -1, "R6 clear vs set 3");
      rd(8'h11, -1, "R6 clear vs set 4");
      wr(8'h04, 8'd7);
      idle(30);

      report();
   end

endmodule